// File: doc/BRIEF.md
# Station Address Match with Clock-Crossing Update

This block keeps a small table of 48-bit station addresses for an Ethernet receiver. Software programs each entry from the host clock as two words: a 32-bit low word carrying address bits [31:0] and a 16-bit high word carrying bits [47:32]. Byte strobes let software change individual lanes. Reads return the host-side copy.

The receive logic uses its own copy of each entry, in the receive clock domain. That copy is refreshed only when software writes one particular byte lane of the low word. Lane 3 is the trigger in little-endian mode and lane 0 in big-endian mode. The write flips a toggle flag, which passes through a two-flop synchronizer. When the receive side sees the flag edge, it latches all 48 host-side bits in a single cycle.

Received bytes arrive on a valid/ready stream with a start-of-frame marker. The first six bytes of each frame form the destination address, and that address is compared against every entry in wire order. The first byte on the wire lines up with bits [7:0]. Each entry has a match flag that is raised after the sixth byte if all 48 bits agree, and dropped when the next frame starts. The stream never applies back-pressure. `rx_ready` goes high at the first receive clock edge after reset and stays high, and a byte is taken on any edge where `rx_valid` and `rx_ready` are both high. Software must leave at least four receive clock cycles between successive low-word writes.

Top module: `sta_addr_filter`

## Requirements
- R1: After reset, every low word reads 0xFFFFFFFF and every high word reads 0x0000FFFF. The receive-domain copies are also all ones, so a frame whose first six bytes are all 0xFF matches every entry. `rx_ready` is high from the first receive clock edge after reset.
- R2: `wr_sel`/`rd_sel` value 2*k selects the low word of entry k, and 2*k+1 selects its high word. The high word uses bits [15:0]. Bits [31:16] of a high-word read are zero, and writes to those bits are ignored.
- R3: A write changes only the byte lanes whose `wr_strb` bit is set. Lane b is bits [8b+7:8b].
- R4: Destination byte i (i = 0 first on the wire) is compared with address bits [8i+7:8i]. The wire bytes 11 22 33 44 55 66 match high word 0x6655 with low word 0x44332211.
- R5: With `cfg_big_endian` = 0, only a low-word write with `wr_strb[3]` = 1 starts a transfer to the receive domain.
- R6: With `cfg_big_endian` = 1, only a low-word write with `wr_strb[0]` = 1 starts a transfer to the receive domain.
- R7: High-word writes and non-triggering low-word writes leave the receive-domain copy unchanged. Frames keep matching the previous value.
- R8: After a triggering write, the full 48-bit host value is used for comparison within four receive clock cycles. This includes any high word written earlier.
- R9: An entry's match flag rises one cycle after the sixth accepted address byte, and only if all 48 bits are equal. A difference in any single byte keeps it low.
- R10: An accepted byte with `rx_sof` = 1 clears all match flags on that edge, so they are low in the following cycle, and it starts a new address.
- R11: Cycles with `rx_valid` low, bytes taken before the first start of frame, and bytes after the sixth are all ignored. The match flags hold their value through them.
- R12: All entries are compared in parallel, and a single frame may raise several match flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Host register clock |
| hrst_n | input | 1 | Host domain asynchronous reset, active low |
| cfg_big_endian | input | 1 | Selects the trigger lane: 0 uses lane 3, 1 uses lane 0 |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | SEL_W | Register index for writes (2*k low, 2*k+1 high) |
| wr_data | input | 32 | Write data |
| wr_strb | input | 4 | Per-lane write strobes |
| rd_sel | input | SEL_W | Register index for reads |
| rd_data | output | 32 | Combinational read data |
| rclk | input | 1 | Receive clock |
| rrst_n | input | 1 | Receive domain asynchronous reset, active low |
| rx_valid | input | 1 | Receive byte valid |
| rx_ready | output | 1 | Always high after reset; no back-pressure |
| rx_data | input | 8 | Receive byte |
| rx_sof | input | 1 | Marks the first byte of a frame |
| match | output | N_ADDR | Per-entry destination address match flags |

## Verification
Two events can land on the same receive clock edge. One is the start of a new frame, which clears the flags and starts a fresh compare. The other is the flag that the sixth byte of the previous frame has just raised. The bench drives two frames back to back with no idle cycle between them, so the match pulse lasts exactly one cycle. A behavioural queue model, checked on every receive clock, must show the same single-cycle pulse. Host writes that leave the trigger lane untouched are paired with frames that still carry the old address. Only the edge after a proper trigger may change the result.

// File: rtl/sta_pkg.sv
package sta_pkg;
  localparam int STA_BYTES = 6;
  localparam int BYTE_W    = 8;
  localparam int STA_W     = STA_BYTES * BYTE_W;
  localparam int LO_W      = 32;
  localparam int HI_W      = STA_W - LO_W;
  localparam int LANES     = LO_W / BYTE_W;
  localparam int HI_LANES  = HI_W / BYTE_W;
  localparam int CNT_W     = $clog2(STA_BYTES + 1);

  typedef logic [STA_W-1:0]  sta_addr_t;
  typedef logic [BYTE_W-1:0] sta_byte_t;

  localparam sta_addr_t STA_RESET = '1;

  // Byte idx of an address, byte 0 being the least significant (first on the wire)
  function automatic sta_byte_t sta_pick(sta_addr_t a, logic [CNT_W-1:0] idx);
    sta_addr_t sh;
    sh = a >> (int'(idx) * BYTE_W);
    return sh[BYTE_W-1:0];
  endfunction
endpackage

// File: rtl/sta_host_regs.sv
module sta_host_regs
  import sta_pkg::*;
#(
  parameter  int N_ADDR = 4,
  localparam int SEL_W  = $clog2(2 * N_ADDR)
) (
  input  logic                     hclk,
  input  logic                     hrst_n,
  input  logic                     cfg_big_endian,
  input  logic                     wr_en,
  input  logic [SEL_W-1:0]         wr_sel,
  input  logic [LO_W-1:0]          wr_data,
  input  logic [LANES-1:0]         wr_strb,
  input  logic [SEL_W-1:0]         rd_sel,
  output logic [LO_W-1:0]          rd_data,
  output sta_addr_t [N_ADDR-1:0]   host_addr,
  output logic [N_ADDR-1:0]        host_tgl
);
  logic trig_strb;
  assign trig_strb = cfg_big_endian ? wr_strb[0] : wr_strb[LANES-1];

  for (genvar g = 0; g < N_ADDR; g++) begin : g_ent
    localparam logic [SEL_W-1:0] LO_SEL = SEL_W'(2 * g);
    localparam logic [SEL_W-1:0] HI_SEL = SEL_W'(2 * g + 1);
    logic [LO_W-1:0] lo_q;
    logic [HI_W-1:0] hi_q;
    logic            tgl_q;
    logic            lo_hit, hi_hit;

    assign lo_hit = wr_en && (wr_sel == LO_SEL);
    assign hi_hit = wr_en && (wr_sel == HI_SEL);

    always_ff @(posedge hclk or negedge hrst_n) begin
      if (!hrst_n) begin
        lo_q  <= STA_RESET[LO_W-1:0];
        hi_q  <= STA_RESET[STA_W-1:LO_W];
        tgl_q <= 1'b0;
      end else begin
        if (lo_hit) begin
          for (int b = 0; b < LANES; b++)
            if (wr_strb[b]) lo_q[b*BYTE_W +: BYTE_W] <= wr_data[b*BYTE_W +: BYTE_W];
          if (trig_strb) tgl_q <= ~tgl_q;
        end
        if (hi_hit) begin
          for (int b = 0; b < HI_LANES; b++)
            if (wr_strb[b]) hi_q[b*BYTE_W +: BYTE_W] <= wr_data[b*BYTE_W +: BYTE_W];
        end
      end
    end

    assign host_addr[g] = {hi_q, lo_q};
    assign host_tgl[g]  = tgl_q;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N_ADDR; i++) begin
      if (rd_sel == SEL_W'(2 * i))     rd_data = host_addr[i][LO_W-1:0];
      if (rd_sel == SEL_W'(2 * i + 1)) rd_data[HI_W-1:0] = host_addr[i][STA_W-1:LO_W];
    end
  end
endmodule

// File: rtl/sta_cdc_capture.sv
module sta_cdc_capture
  import sta_pkg::*;
#(
  parameter int N_ADDR      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   rclk,
  input  logic                   rrst_n,
  input  sta_addr_t [N_ADDR-1:0] host_addr,
  input  logic [N_ADDR-1:0]      host_tgl,
  output sta_addr_t [N_ADDR-1:0] rx_addr
);
  for (genvar g = 0; g < N_ADDR; g++) begin : g_sync
    // [SYNC_STAGES-1:0] synchronizer, [SYNC_STAGES] last seen level
    logic [SYNC_STAGES:0] sync_q;
    sta_addr_t            cap_q;
    logic                 edge_seen;

    assign edge_seen = sync_q[SYNC_STAGES] ^ sync_q[SYNC_STAGES-1];

    always_ff @(posedge rclk or negedge rrst_n) begin
      if (!rrst_n) begin
        sync_q <= '0;
        cap_q  <= STA_RESET;
      end else begin
        sync_q <= {sync_q[SYNC_STAGES-1:0], host_tgl[g]};
        if (edge_seen) cap_q <= host_addr[g];
      end
    end

    assign rx_addr[g] = cap_q;
  end
endmodule

// File: rtl/sta_da_compare.sv
module sta_da_compare
  import sta_pkg::*;
#(
  parameter int N_ADDR = 4
) (
  input  logic                   rclk,
  input  logic                   rrst_n,
  input  logic                   rx_valid,
  output logic                   rx_ready,
  input  logic [BYTE_W-1:0]      rx_data,
  input  logic                   rx_sof,
  input  sta_addr_t [N_ADDR-1:0] rx_addr,
  output logic [N_ADDR-1:0]      match
);
  localparam logic [CNT_W-1:0] DONE = CNT_W'(STA_BYTES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STA_BYTES - 1);

  logic [CNT_W-1:0]  pos_q;
  logic [N_ADDR-1:0] eq_q, match_q, hit;
  logic              ready_q, take;
  logic [CNT_W-1:0]  pos_use;

  assign take    = rx_valid && ready_q;
  assign pos_use = rx_sof ? '0 : pos_q;

  always_comb begin
    for (int i = 0; i < N_ADDR; i++)
      hit[i] = (rx_data == sta_pick(rx_addr[i], pos_use)) && (rx_sof || eq_q[i]);
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      pos_q   <= DONE;
      eq_q    <= '0;
      match_q <= '0;
      ready_q <= 1'b0;
    end else begin
      ready_q <= 1'b1;
      if (take) begin
        if (rx_sof) begin
          pos_q   <= CNT_W'(1);
          eq_q    <= hit;
          match_q <= '0;
        end else if (pos_q != DONE) begin
          pos_q <= pos_q + CNT_W'(1);
          eq_q  <= hit;
          if (pos_q == LAST) match_q <= hit;
        end
      end
    end
  end

  assign rx_ready = ready_q;
  assign match    = match_q;
endmodule

// File: rtl/sta_addr_filter.sv
module sta_addr_filter
  import sta_pkg::*;
#(
  parameter  int N_ADDR = 4,
  localparam int SEL_W  = $clog2(2 * N_ADDR)
) (
  input  logic              hclk,
  input  logic              hrst_n,
  input  logic              cfg_big_endian,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [31:0]       wr_data,
  input  logic [3:0]        wr_strb,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [31:0]       rd_data,
  input  logic              rclk,
  input  logic              rrst_n,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  input  logic              rx_sof,
  output logic [N_ADDR-1:0] match
);
  localparam int SYNC_STAGES = 2;

  sta_addr_t [N_ADDR-1:0] host_addr;
  sta_addr_t [N_ADDR-1:0] rx_addr;
  logic [N_ADDR-1:0]      host_tgl;

  sta_host_regs #(.N_ADDR(N_ADDR)) u_regs (
    .hclk(hclk), .hrst_n(hrst_n), .cfg_big_endian(cfg_big_endian),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .wr_strb(wr_strb),
    .rd_sel(rd_sel), .rd_data(rd_data),
    .host_addr(host_addr), .host_tgl(host_tgl)
  );

  sta_cdc_capture #(.N_ADDR(N_ADDR), .SYNC_STAGES(SYNC_STAGES)) u_cdc (
    .rclk(rclk), .rrst_n(rrst_n),
    .host_addr(host_addr), .host_tgl(host_tgl), .rx_addr(rx_addr)
  );

  sta_da_compare #(.N_ADDR(N_ADDR)) u_cmp (
    .rclk(rclk), .rrst_n(rrst_n),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_sof(rx_sof),
    .rx_addr(rx_addr), .match(match)
  );
endmodule

// File: rtl/sta_addr_filter_chk.sv
module sta_addr_filter_chk
  import sta_pkg::*;
#(
  parameter  int N_ADDR = 4,
  localparam int SEL_W  = $clog2(2 * N_ADDR)
) (
  input logic              hclk,
  input logic              hrst_n,
  input logic              rclk,
  input logic              rrst_n,
  input logic              cfg_big_endian,
  input logic              wr_en,
  input logic [SEL_W-1:0]  wr_sel,
  input logic [3:0]        wr_strb,
  input logic [SEL_W-1:0]  rd_sel,
  input logic [31:0]       rd_data,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              rx_sof,
  input logic [N_ADDR-1:0] match,
  input logic [N_ADDR-1:0] host_tgl
);
  logic trig;
  assign trig = cfg_big_endian ? wr_strb[0] : wr_strb[LANES-1];

  // R2
  hi_upper_zero_chk: assert property (@(posedge hclk) disable iff (!hrst_n)
    rd_sel[0] |-> rd_data[31:16] == 16'h0);

  // R5 R6 R7
  no_stray_toggle_chk: assert property (@(posedge hclk) disable iff (!hrst_n)
    !(wr_en && !wr_sel[0] && trig) |=> $stable(host_tgl));

  for (genvar g = 0; g < N_ADDR; g++) begin : g_flip
    // R5 R6
    trigger_flip_chk: assert property (@(posedge hclk) disable iff (!hrst_n)
      (wr_en && wr_sel == SEL_W'(2 * g) && trig) |=> host_tgl[g] != $past(host_tgl[g]));
  end

  // R10
  sof_clear_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    (rx_valid && rx_ready && rx_sof) |=> match == '0);

  // R11
  idle_hold_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    !(rx_valid && rx_ready) |=> $stable(match));

  // R1
  ready_high_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    $past(rrst_n) |-> rx_ready);
endmodule

bind sta_addr_filter sta_addr_filter_chk #(.N_ADDR(N_ADDR)) u_chk (
  .hclk(hclk), .hrst_n(hrst_n), .rclk(rclk), .rrst_n(rrst_n),
  .cfg_big_endian(cfg_big_endian), .wr_en(wr_en), .wr_sel(wr_sel), .wr_strb(wr_strb),
  .rd_sel(rd_sel), .rd_data(rd_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .rx_sof(rx_sof), .match(match), .host_tgl(host_tgl)
);

// File: tb/sta_addr_filter_tb.sv
module sta_addr_filter_tb;
  localparam int N  = 4;
  localparam int SW = 3;

  logic hclk = 1'b0, rclk = 1'b0, hrst_n = 1'b0, rrst_n = 1'b0;
  logic cfg_big_endian = 1'b0, wr_en = 1'b0;
  logic [SW-1:0] wr_sel = '0, rd_sel = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic [3:0] wr_strb = '0;
  logic rx_valid = 1'b0, rx_ready, rx_sof = 1'b0;
  logic [7:0] rx_data = '0;
  logic [N-1:0] match;

  sta_addr_filter #(.N_ADDR(N)) u_dut (
    .hclk(hclk), .hrst_n(hrst_n), .cfg_big_endian(cfg_big_endian),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .wr_strb(wr_strb),
    .rd_sel(rd_sel), .rd_data(rd_data), .rclk(rclk), .rrst_n(rrst_n),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_sof(rx_sof),
    .match(match)
  );

  always #5 hclk = ~hclk;
  initial begin #2; forever #4 rclk = ~rclk; end

  int n_run = 0, n_fail = 0;
  string cur_tag = "R1";
  bit cmp_on = 1'b0;

  // reference model state
  logic [31:0] m_lo[N];
  logic [15:0] m_hi[N];
  logic [47:0] m_rx[N];
  bit pend[N];
  logic [7:0] q[$];
  bit started = 1'b0, m_ready = 1'b0;
  logic [N-1:0] m_match = '0;

  initial for (int e = 0; e < N; e++) begin
    m_lo[e] = '1; m_hi[e] = '1; m_rx[e] = '1; pend[e] = 1'b0;
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(posedge rclk) begin
    if (!rrst_n) begin
      m_ready = 1'b0; started = 1'b0; q.delete(); m_match = '0;
    end else begin
      if (m_ready && rx_valid) begin
        if (rx_sof) begin
          q.delete(); q.push_back(rx_data); started = 1'b1; m_match = '0;
        end else if (started && q.size() < 6) begin
          q.push_back(rx_data);
          if (q.size() == 6) begin
            logic [47:0] v;
            for (int k = 0; k < 6; k++) v[8*k +: 8] = q[k];
            for (int e = 0; e < N; e++) m_match[e] = (v == m_rx[e]);
          end
        end
      end
      m_ready = 1'b1;
    end
  end

  always @(negedge rclk) begin
    if (cmp_on) begin
      n_run++;
      if ({rx_ready, match} !== {m_ready, m_match}) begin
        n_fail++;
        $display("FAIL %s per-cycle ready/match act=%b exp=%b", cur_tag,
                 {rx_ready, match}, {m_ready, m_match});
      end
    end
  end

  task automatic hwrite(input int sel, input logic [31:0] d, input logic [3:0] s);
    int e;
    @(negedge hclk);
    wr_en = 1'b1; wr_sel = SW'(sel); wr_data = d; wr_strb = s;
    @(negedge hclk);
    wr_en = 1'b0; wr_strb = '0;
    e = sel / 2;
    if (sel % 2 == 0) begin
      for (int b = 0; b < 4; b++) if (s[b]) m_lo[e][8*b +: 8] = d[8*b +: 8];
      if (cfg_big_endian ? s[0] : s[3]) pend[e] = 1'b1;
    end else begin
      for (int b = 0; b < 2; b++) if (s[b]) m_hi[e][8*b +: 8] = d[8*b +: 8];
    end
  endtask

  task automatic settle();
    repeat (4) @(posedge rclk);
    for (int e = 0; e < N; e++) if (pend[e]) begin
      m_rx[e] = {m_hi[e], m_lo[e]}; pend[e] = 1'b0;
    end
    @(negedge rclk);
  endtask

  task automatic hread(input int sel, input logic [31:0] exp, input string tag);
    @(negedge hclk);
    rd_sel = SW'(sel);
    #1;
    check(tag, 64'(rd_data), 64'(exp));
  endtask

  task automatic beat(input logic [7:0] b, input logic sof);
    rx_valid = 1'b1; rx_data = b; rx_sof = sof;
    @(negedge rclk);
  endtask

  task automatic idle(input int n);
    rx_valid = 1'b0; rx_sof = 1'b0;
    repeat (n) @(negedge rclk);
  endtask

  task automatic frame(input logic [47:0] v, input int gap, input int tail);
    if (!rx_valid) @(negedge rclk);
    for (int k = 0; k < 6; k++) begin
      beat(v[8*k +: 8], k == 0);
      if (gap > 0) idle(gap);
    end
    if (tail > 0) idle(tail);
  endtask

  localparam logic [47:0] A0 = 48'h665544332211;

  initial begin
    repeat (3) @(negedge hclk);
    #1; hrst_n = 1'b1; rrst_n = 1'b1;
    @(negedge rclk);
    cmp_on = 1'b1;

    // R1 R2: reset contents
    for (int s = 0; s < 2 * N; s++)
      hread(s, (s % 2 == 0) ? 32'hFFFF_FFFF : 32'h0000_FFFF, "R1 R2 reset read");
    @(negedge rclk);
    check("R1 rx_ready after reset", 64'(rx_ready), 64'd1);

    // R11: bytes before any start of frame are ignored
    cur_tag = "R11";
    for (int k = 0; k < 6; k++) beat(8'hFF, 1'b0);
    idle(1);
    check("R11 pre-sof bytes", 64'(match), 64'h0);

    // R1 R12: all-ones frame matches every entry
    cur_tag = "R12";
    frame('1, 0, 1);
    check("R1 R12 all-ones frame", 64'(match), 64'hF);

    // R4: wire order
    cur_tag = "R4";
    hwrite(1, 32'h0000_6655, 4'b0011);
    hwrite(0, 32'h4433_2211, 4'b1111);
    settle();
    hread(1, 32'h0000_6655, "R2 high read");
    frame(A0, 0, 1);
    check("R4 wire 11..66", 64'(match), 64'h1);

    // R3 R2 R7
    cur_tag = "R7";
    hwrite(2, 32'hAABB_CCDD, 4'b0101);
    hread(2, 32'hFFBB_FFDD, "R3 strobed lanes");
    hwrite(3, 32'h1234_5678, 4'b0011);
    hread(3, 32'h0000_5678, "R2 high word");
    hwrite(3, 32'h9999_0000, 4'b1100);
    hread(3, 32'h0000_5678, "R2 upper high bits ignored");
    settle();
    frame('1, 0, 1);
    check("R7 rx copy unchanged", 64'(match), 64'hE);

    // R5 R8: lane-3 trigger in little-endian mode
    cur_tag = "R5";
    hwrite(2, 32'h7700_0000, 4'b1000);
    settle();
    frame(48'h5678_77BB_FFDD, 0, 1);
    check("R5 R8 full value transferred", 64'(match), 64'h2);

    // R6: big-endian mode
    cur_tag = "R6";
    @(negedge hclk); cfg_big_endian = 1'b1;
    hwrite(4, 32'h0102_0304, 4'b1000);
    settle();
    frame('1, 0, 1);
    check("R6 R7 lane 3 no trigger in BE", 64'(match), 64'hC);
    hwrite(5, 32'h0000_0A0B, 4'b0011);
    hwrite(4, 32'h0000_0005, 4'b0001);
    settle();
    frame(48'h0A0B_01FF_FF05, 0, 1);
    check("R6 lane 0 trigger in BE", 64'(match), 64'h4);
    @(negedge hclk); cfg_big_endian = 1'b0;

    // R9: single-byte differences
    cur_tag = "R9";
    for (int k = 0; k < 6; k++) begin
      frame(A0 ^ (48'h01 << (8 * k)), 0, 1);
      check($sformatf("R9 byte %0d differs", k), 64'(match), 64'h0);
    end
    frame(A0, 0, 1);
    check("R9 exact", 64'(match), 64'h1);

    // R11 R10
    cur_tag = "R11";
    frame(A0, 2, 1);
    check("R11 gaps inside frame", 64'(match), 64'h1);
    beat(8'h00, 1'b0); beat(8'h11, 1'b0); idle(1);
    check("R11 bytes after sixth", 64'(match), 64'h1);
    cur_tag = "R10";
    beat(8'hAA, 1'b1); idle(1);
    check("R10 sof clears", 64'(match), 64'h0);
    frame(A0, 0, 0);
    frame('1, 0, 1);
    check("R10 back-to-back frames", 64'(match), 64'h8);

    // R12: two entries match the same frame
    cur_tag = "R12";
    hwrite(7, 32'h0000_6655, 4'b0011);
    hwrite(6, 32'h4433_2211, 4'b1111);
    settle();
    frame(A0, 0, 1);
    check("R12 two entries", 64'(match), 64'h9);

    idle(2);
    cmp_on = 1'b0;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge hclk);
    n_fail++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule